// File: doc/BRIEF.md
# Voltage Reference Slew Sequencer

This block produces the digital reference target, in millivolts, that a buck regulator's control loop tracks. A five-bit voltage identification code is decoded into a setpoint. The code has two ranges with different step sizes. A separate alternate setpoint input takes over whenever it asks for less than the top of the code range. The block does not jump to the setpoint. It walks the reference toward the setpoint one millivolt at a time, so it behaves like a capacitor-programmed soft-start.

After enable or reset the reference climbs from zero at a slow rate. When it reaches 500 mV, soft-start is complete. From then on every move uses a rate twenty times faster, upward or downward. This covers code changes and switches between the alternate setpoint and the code. While the reference is moving in that post-start phase, the block raises a mask. The mask tells the power-good and under-voltage logic to hold off.

Every port is a plain level signal with no handshake, because the code and the setpoint are levels. The block follows them continuously and has no data stream that could apply back-pressure.

Top module: `vref_slew_seq`

## Requirements
- R1: With effective code bit 4 equal to 1, the target is 600 + 25*(15 - code[3:0]) mV (11111 gives 600, 10000 gives 975).
- R2: With effective code bit 4 equal to 0, the target is 1000 + 50*(15 - code[3:0]) mV (01111 gives 1000, 00000 gives 1750).
- R3: A code bit whose `vid_open` bit is 1 is read as logic 1, whatever `vid_code` carries on that bit.
- R4: When `alt_mv` is below 1750 it becomes the target. Otherwise the decoded code sets the target.
- R5: After reset or enable, `ref_mv` starts at 0 and rises by 1 mV every SLOW_DIV cycles (FAST_DIV*RATIO; 40 by default) until it reaches 500 mV.
- R6: Once soft-start is done, `ref_mv` moves 1 mV toward the target every FAST_DIV cycles (2 by default), in both directions, and stops exactly on the target.
- R7: `slewing` is 1 exactly when enabled and `ref_mv` differs from the registered target. When it is 0, `ref_mv` holds.
- R8: `ss_done` goes to 1 on the step that brings `ref_mv` to 500 mV or onto the target, and stays at 1 until enable drops.
- R9: `pg_mask` is 1 only while `ss_done` is 1 and the reference is slewing. It is 0 before soft-start completes and 0 once the reference has settled.
- R10: With `en` low, `ref_mv` is 0 and `ss_done` is 0 one cycle later. Raising `en` restarts the slow phase.
- R11: A change on the code, open-pin or alternate inputs reaches the registered target one cycle later. The first 1 mV step follows the rate period after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Enable; low clears the reference and restarts soft-start |
| vid_code | input | 5 | Voltage identification code |
| vid_open | input | 5 | Per-bit flag: bit is unconnected and reads as 1 |
| alt_mv | input | 12 | Alternate setpoint in mV; used when below 1750 |
| ref_mv | output | 12 | Slewed reference in mV |
| slewing | output | 1 | Reference is moving toward the target |
| ss_done | output | 1 | Soft-start phase complete |
| pg_mask | output | 1 | Hold power-good and under-voltage checks |

## Verification
An input change counts as applied after the clock edge that follows it. The registered target takes it on the next edge. The n-th millivolt step then lands n rate periods after that edge: 40 cycles per step in the slow phase and 2 in the fast phase. One exception is a restart by `en`, where the count begins at the edge on which `en` is first seen high. For every stimulus the bench computes, from these rules, the exact cycle at which the reference should equal a chosen value. It queues the expected reference, flags and cycle stamp. A monitor compares them on the falling edge of exactly that cycle, so each check lands one full step away from the neighbouring values.

// File: rtl/vref_pkg.sv
package vref_pkg;
  localparam int MV_W      = 12;
  localparam int CODE_W    = 5;
  localparam int LO_BASE   = 600;
  localparam int LO_STEP   = 25;
  localparam int HI_BASE   = 1000;
  localparam int HI_STEP   = 50;
  localparam int HALF_MV   = 500;
  localparam int ALT_LIMIT = 1750;

  typedef logic [MV_W-1:0]   mv_t;
  typedef logic [CODE_W-1:0] code_t;
endpackage

// File: rtl/vref_vid_decode.sv
module vref_vid_decode
  import vref_pkg::*;
(
  input  code_t vid_code,
  input  code_t vid_open,
  output mv_t   vid_mv
);
  localparam int LOW_W = CODE_W - 1;
  localparam int TOP   = (1 << LOW_W) - 1;

  code_t eff;

  // unconnected bits resolve to logic 1
  for (genvar i = 0; i < CODE_W; i++) begin : g_pull
    assign eff[i] = vid_code[i] | vid_open[i];
  end

  always_comb begin
    int idx;
    idx = TOP - int'(eff[LOW_W-1:0]);
    if (eff[CODE_W-1])
      vid_mv = mv_t'(LO_BASE + LO_STEP * idx);
    else
      vid_mv = mv_t'(HI_BASE + HI_STEP * idx);
  end
endmodule

// File: rtl/vref_target_sel.sv
module vref_target_sel
  import vref_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  code_t vid_code,
  input  code_t vid_open,
  input  mv_t   alt_mv,
  output mv_t   tgt_mv
);
  mv_t vid_mv;
  mv_t tgt_d;

  vref_vid_decode u_dec (
    .vid_code (vid_code),
    .vid_open (vid_open),
    .vid_mv   (vid_mv)
  );

  assign tgt_d = (alt_mv < mv_t'(ALT_LIMIT)) ? alt_mv : vid_mv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tgt_mv <= '0;
    else        tgt_mv <= tgt_d;
  end
endmodule

// File: rtl/vref_rate_gen.sv
module vref_rate_gen #(
  parameter int FAST_DIV = 2,
  parameter int RATIO    = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic busy,
  input  logic fast,
  output logic tick
);
  localparam int SLOW_DIV = FAST_DIV * RATIO;
  localparam int CNT_W    = $clog2(SLOW_DIV + 1);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lim;

  assign lim  = fast ? CNT_W'(FAST_DIV - 1) : CNT_W'(SLOW_DIV - 1);
  assign tick = en && busy && (cnt == lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    cnt <= '0;
    else if (!en || !busy || tick) cnt <= '0;
    else                           cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/vref_ramp.sv
module vref_ramp
  import vref_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic tick,
  input  mv_t  tgt_mv,
  output mv_t  ref_mv,
  output logic ss_done
);
  mv_t ref_nxt;
  logic hit_done;

  assign ref_nxt  = (ref_mv < tgt_mv) ? ref_mv + 1'b1 : ref_mv - 1'b1;
  assign hit_done = (ref_nxt >= mv_t'(HALF_MV)) || (ref_nxt == tgt_mv);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_mv  <= '0;
      ss_done <= 1'b0;
    end else if (!en) begin
      ref_mv  <= '0;
      ss_done <= 1'b0;
    end else if (tick) begin
      ref_mv  <= ref_nxt;
      ss_done <= ss_done | hit_done;
    end
  end
endmodule

// File: rtl/vref_slew_seq.sv
module vref_slew_seq
  import vref_pkg::*;
#(
  parameter int FAST_DIV = 2,
  parameter int RATIO    = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [CODE_W-1:0] vid_code,
  input  logic [CODE_W-1:0] vid_open,
  input  logic [MV_W-1:0]   alt_mv,
  output logic [MV_W-1:0]   ref_mv,
  output logic              slewing,
  output logic              ss_done,
  output logic              pg_mask
);
  mv_t  tgt_mv;
  logic tick;
  logic busy;

  vref_target_sel u_tgt (
    .clk      (clk),
    .rst_n    (rst_n),
    .vid_code (vid_code),
    .vid_open (vid_open),
    .alt_mv   (alt_mv),
    .tgt_mv   (tgt_mv)
  );

  assign busy = en && (ref_mv != tgt_mv);

  vref_rate_gen #(.FAST_DIV(FAST_DIV), .RATIO(RATIO)) u_rate (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (en),
    .busy  (busy),
    .fast  (ss_done),
    .tick  (tick)
  );

  vref_ramp u_ramp (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (en),
    .tick    (tick),
    .tgt_mv  (tgt_mv),
    .ref_mv  (ref_mv),
    .ss_done (ss_done)
  );

  assign slewing = busy;
  assign pg_mask = ss_done && busy;
endmodule

// File: rtl/vref_slew_chk.sv
module vref_slew_chk
  import vref_pkg::*;
(
  input logic clk,
  input logic rst_n,
  input logic en,
  input mv_t  ref_mv,
  input logic slewing,
  input logic ss_done,
  input logic pg_mask
);
  // R6: reference moves by at most one millivolt per cycle
  a_r6_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(en) && en) |-> (ref_mv == $past(ref_mv) || ref_mv == $past(ref_mv) + 1'b1 ||
                           ref_mv + 1'b1 == $past(ref_mv)));

  // R5: during soft-start no two consecutive cycles both step
  a_r5_slow_phase: assert property (@(posedge clk) disable iff (!rst_n)
    (!ss_done && en && $past(en) && ref_mv != $past(ref_mv)) |-> ($past(ref_mv) == $past(ref_mv, 2)));

  // R7: settled reference holds
  a_r7_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!slewing && en) |=> $stable(ref_mv));

  // R8: soft-start completion is sticky while enabled
  a_r8_ss_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ss_done && en) |=> ss_done);

  // R10: disable clears reference and phase
  a_r10_disable_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (ref_mv == '0 && !ss_done && !pg_mask));
endmodule

bind vref_slew_seq vref_slew_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .en      (en),
  .ref_mv  (ref_mv),
  .slewing (slewing),
  .ss_done (ss_done),
  .pg_mask (pg_mask)
);

// File: tb/sim_vref_slew_seq.sv
module sim_vref_slew_seq;
  localparam int CLK_PERIOD = 10;
  localparam int FAST = 2;
  localparam int SLOW = 40;
  localparam int WDOG = 150000;

  typedef struct {
    int    due;
    int    refv;
    bit    slew;
    bit    ssd;
    bit    pgm;
    string tag;
  } exp_t;

  logic clk = 0;
  logic rst_n = 0;
  logic en = 1;
  logic [4:0] vid_code = 5'b11111;
  logic [4:0] vid_open = 5'b00000;
  logic [11:0] alt_mv = 12'hFFF;
  logic [11:0] ref_mv;
  logic slewing, ss_done, pg_mask;

  int cyc = 0;
  int n_chk = 0;
  int n_bad = 0;
  exp_t q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  vref_slew_seq u0 (
    .clk(clk), .rst_n(rst_n), .en(en), .vid_code(vid_code), .vid_open(vid_open),
    .alt_mv(alt_mv), .ref_mv(ref_mv), .slewing(slewing), .ss_done(ss_done), .pg_mask(pg_mask)
  );

  function automatic int code_mv(input logic [4:0] c, input logic [4:0] o);
    logic [4:0] e;
    e = c | o;
    if (e[4]) return 600 + 25 * (15 - int'(e[3:0]));  // R1
    return 1000 + 50 * (15 - int'(e[3:0]));            // R2
  endfunction

  task automatic compare(input string tag, input int rv, input bit sl, input bit sd, input bit pm);
    n_chk++;
    if (int'(ref_mv) != rv || slewing != sl || ss_done != sd || pg_mask != pm) begin
      n_bad++;
      $display("FAIL %s cyc=%0d: ref=%0d slew=%0b ss=%0b pgm=%0b expected ref=%0d slew=%0b ss=%0b pgm=%0b",
               tag, cyc, ref_mv, slewing, ss_done, pg_mask, rv, sl, sd, pm);
    end
  endtask

  task automatic push(input int due, input int rv, input bit sl, input bit sd, input bit pm, input string tag);
    exp_t e;
    e.due = due; e.refv = rv; e.slew = sl; e.ssd = sd; e.pgm = pm; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic wait_to(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  // monitor
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due <= cyc) begin
      exp_t e;
      e = q.pop_front();
      if (e.due < cyc) begin
        n_chk++; n_bad++;
        $display("FAIL %s: check missed, due=%0d now=%0d expected ref=%0d", e.tag, e.due, cyc, e.refv);
      end else
        compare(e.tag, e.refv, e.slew, e.ssd, e.pgm);
    end
    if (cyc > WDOG) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: cyc=%0d expected finish before %0d", cyc, WDOG);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  // post-start move: inputs already driven at this negedge (cyc=k)
  task automatic fast_move(input int from, input int to, input string tag);
    int k, d, dir;
    k = cyc;
    d = (to > from) ? to - from : from - to;
    dir = (to > from) ? 1 : -1;
    push(k + 1, from, 1, 1, 1, {tag, " R11 latched"});
    push(k + 1 + (d / 2) * FAST, from + dir * (d / 2), 1, 1, 1, {tag, " R6 R9 mid"});
    push(k + 1 + d * FAST, to, 0, 1, 0, {tag, " R6 R7 settled"});
    wait_to(k + 3 + d * FAST);
  endtask

  initial begin
    int r, m, cur, nxt;
    repeat (3) @(negedge clk);
    compare("R10 reset state", 0, 0, 0, 0);
    rst_n = 1;
    r = cyc;
    cur = code_mv(5'b11111, 5'b0);
    push(r + 1, 0, 1, 0, 0, "R11 R9 start latched");
    push(r + 1 + 100 * SLOW, 100, 1, 0, 0, "R5 slow ramp");
    push(r + 1 + 499 * SLOW, 499, 1, 0, 0, "R5 R8 just below half");
    push(r + 1 + 500 * SLOW, 500, 1, 1, 1, "R8 R9 half reached");
    push(r + 1 + 500 * SLOW + (cur - 500) * FAST, cur, 0, 1, 0, "R1 R6 start settled 600");
    wait_to(r + 3 + 500 * SLOW + (cur - 500) * FAST);

    vid_code = 5'b10000; nxt = code_mv(vid_code, vid_open);
    fast_move(cur, nxt, "R1 up to 975"); cur = nxt;
    vid_code = 5'b11101; nxt = code_mv(vid_code, vid_open);
    fast_move(cur, nxt, "R1 down to 650"); cur = nxt;
    vid_code = 5'b00000; nxt = code_mv(vid_code, vid_open);
    fast_move(cur, nxt, "R2 up to 1750"); cur = nxt;
    vid_code = 5'b01111; nxt = code_mv(vid_code, vid_open);
    fast_move(cur, nxt, "R2 down to 1000"); cur = nxt;
    alt_mv = 12'd1200;
    fast_move(cur, 1200, "R4 alt override"); cur = 1200;
    vid_code = 5'b00000;
    alt_mv = 12'd1750;
    fast_move(cur, 1750, "R4 alt at limit ignored"); cur = 1750;
    vid_open = 5'b10000; nxt = code_mv(vid_code, vid_open);
    fast_move(cur, nxt, "R3 open bit4"); cur = nxt;
    vid_open = 5'b11111; nxt = 600;
    fast_move(cur, nxt, "R3 all open"); cur = nxt;

    // R10 disable and restart
    en = 0;
    push(cyc + 1, 0, 0, 0, 0, "R10 disabled clear");
    vid_open = 5'b00000; vid_code = 5'b01010;
    repeat (5) @(negedge clk);
    en = 1;
    m = cyc;
    nxt = code_mv(vid_code, vid_open);
    push(m + 100 * SLOW, 100, 1, 0, 0, "R10 R5 restart slow");
    push(m + 500 * SLOW, 500, 1, 1, 1, "R10 R8 restart half");
    push(m + 500 * SLOW + (nxt - 500) * FAST, nxt, 0, 1, 0, "R2 R6 restart settled 1250");
    wait_to(m + 2 + 500 * SLOW + (nxt - 500) * FAST);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule